// File: doc/BRIEF.md
# Sorted Timer-Event Queue

This block holds pending thread wake-up events ordered by expiry time and releases each thread as soon as its delay has elapsed. A requester hands over a thread identifier together with a relative delay in clock ticks. The block adds that delay to a free-running tick counter to get an absolute deadline. It then inserts the event at its sorted position in a small array of register slots.

Because the array is always kept in deadline order, only the head slot is compared with the current time, and it is compared on every cycle. The wake-up resolution is therefore exactly one clock period, and the amount of logic per cycle does not grow with the queue length. When the head is due, it moves into an output register. From there the thread identifier is offered on a valid/ready message port, and one handshake completes the wake-up. The slot is then free, and the next head is watched.

The surrounding interconnect, the scheduler that consumes the wake-up and any early cancellation of a pending sleep lie outside this block.

Top module: `wake_timer_queue`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `wake_valid` is 0 and `req_ready` is 1. The queue is empty, so no message appears until a request has been accepted.
- R2: A request is taken on a cycle with `req_valid` and `req_ready` both high, and each such cycle adds exactly one entry. `req_ready` stays high while fewer than DEPTH entries are held.
- R3: The deadline of an entry is the tick count in its acceptance cycle plus `req_delay`, and the tick count advances by one every cycle. With an idle queue and `wake_ready` high, `wake_valid` first goes high d+1 cycles after the acceptance cycle for a delay d of 1 or more. For a delay of 0 it goes high 2 cycles after acceptance.
- R4: Wake-up messages leave in ascending deadline order, whatever the order of arrival.
- R5: Entries with equal deadlines leave in the order in which they were accepted.
- R6: While DEPTH entries are held, `req_ready` is 0. A request presented then is not taken, and no message for it ever appears.
- R7: Once `wake_valid` is high, it stays high and `wake_tid` stays unchanged until a cycle in which `wake_ready` is high. A message completes on a cycle with both signals high. The next due entry may be presented in the following cycle.
- R8: Entries that fall due while a message is waiting stay queued, and none is lost. They are sent after that message, in deadline order.
- R9: When a head removal and an insertion fall in the same cycle, both take effect. The removal comes first, and the new entry is placed in order among the remaining entries.
- R10: Deadlines are compared modulo 2^TIME_W through the sign of their difference, so delays must stay below 2^(TIME_W-1). An entry with delay 2^(TIME_W-1)-1 sorts after shorter ones and does not expire early.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | A sleep request is offered |
| req_ready | output | 1 | The queue has a free slot and accepts the request |
| req_tid | input | ID_W | Thread identifier of the request |
| req_delay | input | TIME_W | Relative delay in clock ticks |
| wake_valid | output | 1 | A wake-up message is offered |
| wake_ready | input | 1 | The receiver takes the wake-up message |
| wake_tid | output | ID_W | Thread identifier to be woken |

## Verification
Removing the due head and inserting a new request are the two functions that can land in the same cycle. This is provoked in two ways. In the first, a request is placed in exactly the cycle in which an earlier short sleep is popped, with a delay that must put it in front of an entry that is still queued. In the second, a back-to-back stream of equal-delay requests keeps removals and insertions overlapping for several cycles. A behavioural model, built on an ordered list, predicts `req_ready`, `wake_valid` and `wake_tid` on every cycle. The delivered identifier order is checked against hand-derived sequences. A bound property requires the occupancy to stay unchanged whenever both functions fire together.

// File: rtl/wtq_pkg.sv
package wtq_pkg;

  // How a slot picks its next contents during an update
  typedef enum logic [1:0] {
    SEL_KEEP  = 2'd0,  // keep the entry left after a possible head removal
    SEL_NEW   = 2'd1,  // load the incoming request
    SEL_SHIFT = 2'd2   // take the neighbour nearer the head (make room)
  } slot_sel_e;

endpackage

// File: rtl/wtq_timebase.sv
module wtq_timebase #(
  parameter int unsigned TIME_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [TIME_W-1:0] now_o
);

  logic [TIME_W-1:0] tick_q;
  logic [TIME_W-1:0] tick_d;

  always_comb begin
    tick_d = tick_q + TIME_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
    end else begin
      tick_q <= tick_d;
    end
  end

  assign now_o = tick_q;

endmodule

// File: rtl/wtq_slot.sv
module wtq_slot
  import wtq_pkg::*;
#(
  parameter int unsigned ID_W    = 8,
  parameter int unsigned TIME_W  = 32,
  parameter bit          IS_HEAD = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_i,
  input  logic              pop_i,
  input  logic [ID_W-1:0]   new_tid_i,
  input  logic [TIME_W-1:0] new_dl_i,
  // entry this slot holds once any head removal is applied
  input  logic              own_vld_i,
  input  logic [ID_W-1:0]   own_tid_i,
  input  logic [TIME_W-1:0] own_dl_i,
  // same view of the neighbour one position nearer the head
  input  logic              up_vld_i,
  input  logic [ID_W-1:0]   up_tid_i,
  input  logic [TIME_W-1:0] up_dl_i,
  input  logic              up_le_i,
  output logic              le_o,
  output logic              vld_o,
  output logic [ID_W-1:0]   tid_o,
  output logic [TIME_W-1:0] dl_o
);

  logic [TIME_W-1:0] gap;
  slot_sel_e         sel;
  logic              upd_en;
  logic              vld_d;
  logic [ID_W-1:0]   tid_d;
  logic [TIME_W-1:0] dl_d;
  logic              vld_q;
  logic [ID_W-1:0]   tid_q;
  logic [TIME_W-1:0] dl_q;

  // Held entry is not later than the new one (wrap-safe); ties keep arrival order
  always_comb begin
    gap  = own_dl_i - new_dl_i;
    le_o = own_vld_i && (gap[TIME_W-1] || (gap == '0));
  end

  always_comb begin
    if (!ins_i || le_o) begin
      sel = SEL_KEEP;
    end else if (IS_HEAD || up_le_i) begin
      sel = SEL_NEW;
    end else begin
      sel = SEL_SHIFT;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_NEW: begin
        vld_d = 1'b1;
        tid_d = new_tid_i;
        dl_d  = new_dl_i;
      end
      SEL_SHIFT: begin
        vld_d = up_vld_i;
        tid_d = up_tid_i;
        dl_d  = up_dl_i;
      end
      default: begin
        vld_d = own_vld_i;
        tid_d = own_tid_i;
        dl_d  = own_dl_i;
      end
    endcase
    upd_en = pop_i || (sel != SEL_KEEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else if (upd_en) begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en) begin
      tid_q <= tid_d;
      dl_q  <= dl_d;
    end
  end

  assign vld_o = vld_q;
  assign tid_o = tid_q;
  assign dl_o  = dl_q;

endmodule

// File: rtl/wtq_queue.sv
module wtq_queue #(
  parameter int unsigned ID_W   = 8,
  parameter int unsigned TIME_W = 32,
  parameter int unsigned DEPTH  = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [TIME_W-1:0]            now_i,
  input  logic                         ins_i,
  input  logic [ID_W-1:0]              new_tid_i,
  input  logic [TIME_W-1:0]            new_dl_i,
  input  logic                         pop_i,
  output logic                         head_due_o,
  output logic [ID_W-1:0]              head_tid_o,
  output logic                         full_o,
  output logic [DEPTH-1:0]             vld_o,
  output logic [DEPTH-1:0][TIME_W-1:0] dl_o
);

  localparam int unsigned LAST = DEPTH - 1;

  logic [DEPTH-1:0]             vld_q;
  logic [DEPTH-1:0][ID_W-1:0]   tid_q;
  logic [DEPTH-1:0][TIME_W-1:0] dl_q;

  // Contents after an optional head removal (everything moves up by one)
  logic [DEPTH-1:0]             base_vld;
  logic [DEPTH-1:0][ID_W-1:0]   base_tid;
  logic [DEPTH-1:0][TIME_W-1:0] base_dl;

  logic [DEPTH-1:0]             up_vld;
  logic [DEPTH-1:0][ID_W-1:0]   up_tid;
  logic [DEPTH-1:0][TIME_W-1:0] up_dl;
  logic [DEPTH-1:0]             up_le;
  logic [DEPTH-1:0]             le;

  logic [TIME_W-1:0]            head_gap;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    if (i == LAST) begin : g_tail
      assign base_vld[i] = pop_i ? 1'b0 : vld_q[i];
      assign base_tid[i] = tid_q[i];
      assign base_dl[i]  = dl_q[i];
    end else begin : g_body
      assign base_vld[i] = pop_i ? vld_q[i+1] : vld_q[i];
      assign base_tid[i] = pop_i ? tid_q[i+1] : tid_q[i];
      assign base_dl[i]  = pop_i ? dl_q[i+1]  : dl_q[i];
    end

    if (i == 0) begin : g_top
      assign up_vld[i] = 1'b0;
      assign up_tid[i] = '0;
      assign up_dl[i]  = '0;
      assign up_le[i]  = 1'b0;
    end else begin : g_link
      assign up_vld[i] = base_vld[i-1];
      assign up_tid[i] = base_tid[i-1];
      assign up_dl[i]  = base_dl[i-1];
      assign up_le[i]  = le[i-1];
    end

    wtq_slot #(
      .ID_W    (ID_W),
      .TIME_W  (TIME_W),
      .IS_HEAD (i == 0)
    ) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .ins_i     (ins_i),
      .pop_i     (pop_i),
      .new_tid_i (new_tid_i),
      .new_dl_i  (new_dl_i),
      .own_vld_i (base_vld[i]),
      .own_tid_i (base_tid[i]),
      .own_dl_i  (base_dl[i]),
      .up_vld_i  (up_vld[i]),
      .up_tid_i  (up_tid[i]),
      .up_dl_i   (up_dl[i]),
      .up_le_i   (up_le[i]),
      .le_o      (le[i]),
      .vld_o     (vld_q[i]),
      .tid_o     (tid_q[i]),
      .dl_o      (dl_q[i])
    );
  end

  // Only the head is watched: due once (now - deadline) is non-negative
  always_comb begin
    head_gap   = now_i - dl_q[0];
    head_due_o = vld_q[0] && !head_gap[TIME_W-1];
  end

  assign head_tid_o = tid_q[0];
  assign full_o     = vld_q[LAST];
  assign vld_o      = vld_q;
  assign dl_o       = dl_q;

endmodule

// File: rtl/wtq_wake_port.sv
module wtq_wake_port #(
  parameter int unsigned ID_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            due_i,
  input  logic [ID_W-1:0] tid_i,
  input  logic            ready_i,
  output logic            take_o,
  output logic            valid_o,
  output logic [ID_W-1:0] tid_o
);

  logic            valid_q;
  logic            valid_d;
  logic [ID_W-1:0] tid_q;
  logic            valid_en;

  // The head may move here when the register is empty or being drained
  always_comb begin
    take_o   = due_i && (!valid_q || ready_i);
    valid_en = take_o || ready_i;
    valid_d  = take_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else if (valid_en) begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (take_o) begin
      tid_q <= tid_i;
    end
  end

  assign valid_o = valid_q;
  assign tid_o   = tid_q;

endmodule

// File: rtl/wake_timer_queue.sv
module wake_timer_queue #(
  parameter int unsigned ID_W   = 8,
  parameter int unsigned TIME_W = 32,
  parameter int unsigned DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ID_W-1:0]   req_tid,
  input  logic [TIME_W-1:0] req_delay,
  output logic              wake_valid,
  input  logic              wake_ready,
  output logic [ID_W-1:0]   wake_tid
);

  logic [TIME_W-1:0]            now;
  logic [TIME_W-1:0]            new_dl;
  logic                         ins;
  logic                         pop;
  logic                         head_due;
  logic [ID_W-1:0]              head_tid;
  logic                         full;
  logic [DEPTH-1:0]             q_vld;
  logic [DEPTH-1:0][TIME_W-1:0] q_dl;

  always_comb begin
    req_ready = !full;
    ins       = req_valid && req_ready;
    new_dl    = now + req_delay;
  end

  wtq_timebase #(
    .TIME_W (TIME_W)
  ) u_timebase (
    .clk   (clk),
    .rst_n (rst_n),
    .now_o (now)
  );

  wtq_queue #(
    .ID_W   (ID_W),
    .TIME_W (TIME_W),
    .DEPTH  (DEPTH)
  ) u_queue (
    .clk        (clk),
    .rst_n      (rst_n),
    .now_i      (now),
    .ins_i      (ins),
    .new_tid_i  (req_tid),
    .new_dl_i   (new_dl),
    .pop_i      (pop),
    .head_due_o (head_due),
    .head_tid_o (head_tid),
    .full_o     (full),
    .vld_o      (q_vld),
    .dl_o       (q_dl)
  );

  wtq_wake_port #(
    .ID_W (ID_W)
  ) u_wake (
    .clk     (clk),
    .rst_n   (rst_n),
    .due_i   (head_due),
    .tid_i   (head_tid),
    .ready_i (wake_ready),
    .take_o  (pop),
    .valid_o (wake_valid),
    .tid_o   (wake_tid)
  );

endmodule

// File: rtl/wtq_checker.sv
module wtq_checker #(
  parameter int unsigned ID_W   = 8,
  parameter int unsigned TIME_W = 32,
  parameter int unsigned DEPTH  = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         req_valid,
  input logic                         req_ready,
  input logic                         wake_valid,
  input logic                         wake_ready,
  input logic [ID_W-1:0]              wake_tid,
  input logic                         pop,
  input logic [TIME_W-1:0]            now,
  input logic [DEPTH-1:0]             q_vld,
  input logic [DEPTH-1:0][TIME_W-1:0] q_dl
);

  AST_TICK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> now == $past(now) + TIME_W'(1)); // R3

  AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wake_valid && !wake_ready |=> wake_valid && $stable(wake_tid)); // R7

  AST_OCC_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    (q_vld & (q_vld + 1'b1)) == '0); // R2

  AST_ADD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !pop |=> $countones(q_vld) == $past($countones(q_vld)) + 1); // R2

  AST_REFUSED_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready && !pop |=> $stable(q_vld)); // R6

  AST_SWAP_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && pop |=> $stable(q_vld)); // R9

  for (genvar i = 0; i + 1 < DEPTH; i++) begin : g_order
    logic [TIME_W-1:0] step;
    assign step = q_dl[i+1] - q_dl[i];
    AST_SORTED: assert property (@(posedge clk) disable iff (!rst_n)
      q_vld[i+1] |-> !step[TIME_W-1]); // R4
  end

endmodule

bind wake_timer_queue wtq_checker #(
  .ID_W   (ID_W),
  .TIME_W (TIME_W),
  .DEPTH  (DEPTH)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .wake_valid (wake_valid),
  .wake_ready (wake_ready),
  .wake_tid   (wake_tid),
  .pop        (pop),
  .now        (now),
  .q_vld      (q_vld),
  .q_dl       (q_dl)
);

// File: tb/wake_timer_queue_tb.sv
`timescale 1ns/1ps
module wake_timer_queue_tb;

  localparam int DEPTH = 8;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [7:0]  req_tid;
  logic [31:0] req_delay;
  logic        wake_valid;
  logic        wake_ready;
  logic [7:0]  wake_tid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  wake_timer_queue u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_tid    (req_tid),
    .req_delay  (req_delay),
    .wake_valid (wake_valid),
    .wake_ready (wake_ready),
    .wake_tid   (wake_tid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct {
    logic [7:0]  tid;
    logic [31:0] dl;
  } m_ent_t;

  m_ent_t      mq[$];
  logic [31:0] m_now;
  logic        m_ov;
  logic [7:0]  m_otid;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete();
      m_now  = 0;
      m_ov   = 0;
      m_otid = 0;
    end else begin
      bit     due;
      bit     take;
      bit     acc;
      int     p;
      m_ent_t e;
      due  = (mq.size() > 0) && ($signed(m_now - mq[0].dl) >= 0);
      take = due && (!m_ov || wake_ready);
      acc  = req_valid && (mq.size() < DEPTH);
      if (take) begin
        m_ov   = 1;
        m_otid = mq[0].tid;
        void'(mq.pop_front());
      end else if (wake_ready) begin
        m_ov = 0;
      end
      if (acc) begin
        e.tid = req_tid;
        e.dl  = m_now + req_delay;
        p = 0;
        while (p < mq.size() && $signed(mq[p].dl - e.dl) <= 0) p++;
        mq.insert(p, e);
      end
      m_now = m_now + 1;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(req_ready === (mq.size() < DEPTH), "R6 model ready", req_ready, mq.size() < DEPTH);
      check(wake_valid === m_ov, "R3 model wake_valid", wake_valid, m_ov);
      if (m_ov && wake_valid === 1'b1)
        check(wake_tid === m_otid, "R4 model wake_tid", wake_tid, m_otid);
    end
  end

  // delivered identifiers
  logic [7:0] got[$];
  logic [7:0] want[$];

  always @(posedge clk) begin
    if (rst_n && wake_valid && wake_ready) got.push_back(wake_tid);
  end

  task automatic cmp_got(input string req);
    check(got.size() == want.size(), {req, " message count"}, got.size(), want.size());
    for (int i = 0; i < want.size() && i < got.size(); i++)
      check(got[i] === want[i], {req, " message order"}, got[i], want[i]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(wake_valid === 1'b0, "R1 valid in reset", wake_valid, 0);
    check(req_ready === 1'b1, "R1 ready in reset", req_ready, 1);
    rst_n = 1'b1;
  endtask

  task automatic send(input logic [7:0] tid, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1;
    req_tid   = tid;
    req_delay = d;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic latency(input logic [31:0] d, input int exp);
    int n;
    send(8'h05, d);
    @(negedge clk);
    req_valid = 1'b0;
    n = 1;
    while (!wake_valid && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(n == exp, "R3 wake latency", n, exp);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_n      = 1'b0;
    req_valid  = 1'b0;
    req_tid    = '0;
    req_delay  = '0;
    wake_ready = 1'b1;
    do_reset();
    @(negedge clk);
    check(wake_valid === 1'b0, "R1 valid after reset", wake_valid, 0);
    check(req_ready === 1'b1, "R1 ready after reset", req_ready, 1);
    repeat (5) @(negedge clk);
    check(wake_valid === 1'b0, "R1 no spurious message", wake_valid, 0);

    // R3: resolution of one cycle, zero delay wakes on the next check
    latency(0, 2);
    latency(1, 2);
    latency(5, 6);
    latency(17, 18);

    // R4: arrival order differs from deadline order
    got.delete();
    send(8'd10, 30);
    send(8'd11, 10);
    send(8'd12, 20);
    idle(45);
    want = '{8'd11, 8'd12, 8'd10};
    cmp_got("R4");

    // R5: equal deadlines, arrival order kept
    got.delete();
    send(8'd20, 12);
    send(8'd21, 11);
    send(8'd22, 10);
    idle(25);
    want = '{8'd20, 8'd21, 8'd22};
    cmp_got("R5");

    // R2 / R6: filling up and refusing
    got.delete();
    for (int i = 0; i < 7; i++) send(8'(80 + i), 300);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready === 1'b1, "R2 ready with one free slot", req_ready, 1);
    send(8'd87, 300);
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready === 1'b0, "R6 ready when full", req_ready, 0);
    req_valid = 1'b1;
    req_tid   = 8'd99;
    req_delay = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(req_ready === 1'b0, "R6 refused while full", req_ready, 0);
    end
    idle(320);
    want = '{8'd80, 8'd81, 8'd82, 8'd83, 8'd84, 8'd85, 8'd86, 8'd87};
    cmp_got("R6");

    // R7 / R8: receiver stalls while more entries fall due
    got.delete();
    wake_ready = 1'b0;
    send(8'd30, 3);
    send(8'd31, 1);
    send(8'd32, 2);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 20 && !wake_valid; i++) @(negedge clk);
    check(wake_tid === 8'd31, "R4 first due under stall", wake_tid, 31);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      check(wake_valid === 1'b1 && wake_tid === 8'd31, "R7 held message", {wake_valid, wake_tid}, {1'b1, 8'd31});
    end
    wake_ready = 1'b1;
    repeat (10) @(negedge clk);
    want = '{8'd31, 8'd30, 8'd32};
    cmp_got("R8");

    // R9: head removal and insertion in the same cycle
    got.delete();
    send(8'd60, 2);
    send(8'd61, 40);
    send(8'd62, 5);
    idle(60);
    want = '{8'd60, 8'd62, 8'd61};
    cmp_got("R9 overlap placement");

    got.delete();
    for (int i = 0; i < 10; i++) send(8'(100 + i), 3);
    idle(20);
    want.delete();
    for (int i = 0; i < 10; i++) want.push_back(8'(100 + i));
    cmp_got("R9 streaming");

    // R10: near half-range delay sorts last and does not expire
    got.delete();
    send(8'd70, 32'h7FFF_FFFF);
    send(8'd71, 3);
    idle(50);
    want = '{8'd71};
    cmp_got("R10");
    check(wake_valid === 1'b0, "R10 long sleep still pending", wake_valid, 0);

    do_reset();
    got.delete();
    idle(10);
    check(got.size() == 0, "R1 reset discards pending", got.size(), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule